// File: doc/BRIEF.md
# Credit-Based Shared DRAM Channel Arbiter

This block lets several request sources share a single DRAM channel. Each source offers the head of its request queue as a valid flag and a data word. Once per cycle the arbiter picks at most one of these sources and sends its request into a fixed-latency delay queue. The delay queue then hands requests to the DRAM in the order they were issued, each one only after its latency has run out.

Issue is paced by credits. Every source owns one private credit of its own. All sources also draw on a common shared pool, whose size comes from the depths of the DRAM scheduler queue and the DRAM return queue. If either of those depths is set to zero, the pool has no limit.

Responses from the DRAM carry a global source number. The block turns that number into a local index, using the channel number, and pushes the response into that source's response queue. That push returns one credit. A first-level writeback response is consumed without being pushed and without returning a credit. When the target response queue is full, the response stays at the head of the return queue.

Top module: `credit_dram_arbiter`

## Requirements
- R1: After synchronous active-low reset, `req_pop`, `dram_valid` and `rsp_push` are all zero. The first scan starts at source 0, so when all sources request together the issue order is 0, 1, 2, 3.
- R2: `req_pop` has at most one bit set in any cycle. The scan starts at the source after the last one that borrowed a credit and wraps modulo N_SRC. For example, if source 2 issued last and sources 0, 1 and 3 then request together, the order is 3, 0, 1.
- R3: A source is issued only when three things hold: its `req_valid` bit is 1, it has a credit, and its `rsp_full` bit is 0. A source whose `rsp_full` bit is set is skipped in favour of the next eligible source.
- R4: While `dram_full` is 1, `req_pop` is zero and `dram_valid` is zero.
- R5: A borrow takes the source's private credit first, if it is unused. So a source with no outstanding request can always issue, even when the shared pool is exhausted.
- R6: The shared pool holds SCHED_DEPTH + RETQ_DEPTH − (N_SRC − 1) credits. With the defaults of 4, 4 and 4 sources that is 5, so one source alone can have 6 requests outstanding. If SCHED_DEPTH or RETQ_DEPTH is 0, the pool is unlimited and one source can issue every cycle.
- R7: A request popped in cycle c appears on `dram_valid`/`dram_src`/`dram_data` in cycle c + LATENCY if `dram_full` is 0, and never earlier. Requests leave in the order they were issued.
- R8: A return with `ret_gid` = g goes to local source g − CHAN_ID × N_SRC. `rsp_push` has exactly that bit set, `rsp_data` equals `ret_data`, and `ret_pop` is 1 in the same cycle.
- R9: While the target source's `rsp_full` bit is 1, `ret_pop` and `rsp_push` are 0 and the return is held.
- R10: A return with `ret_wb` = 1 is popped (`ret_pop` = 1) without any `rsp_push`, and it gives back no credit.
- R11: Each pushed, non-writeback return gives back one credit to its source. The private credit is released first, then the shared pool. A source that was stalled on credits issues again afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | N_SRC | Request queue of each source is non-empty |
| req_data | input | N_SRC*DATA_W | Head request of each source, source i at bits i*DATA_W |
| req_pop | output | N_SRC | One-hot pop of the issued source's request queue |
| rsp_full | input | N_SRC | Response queue of each source is full |
| dram_full | input | 1 | DRAM input cannot accept a request |
| dram_valid | output | 1 | Request handed to the DRAM this cycle |
| dram_data | output | DATA_W | Request data toward the DRAM |
| dram_src | output | SRC_W | Local source index of that request |
| ret_valid | input | 1 | DRAM return queue head is valid |
| ret_gid | input | GID_W | Global source number of the return |
| ret_wb | input | 1 | Return is a first-level writeback completion |
| ret_data | input | DATA_W | Return data |
| ret_pop | output | 1 | Return queue head consumed |
| rsp_push | output | N_SRC | One-hot push into a source's response queue |
| rsp_data | output | DATA_W | Data pushed into the response queue |

## Verification
A credit count that drifts upward shows up as a source stalling too early. With the defaults this means fewer than six of one source's requests reach the DRAM before issue stops. A count that drifts downward lets a seventh request through, or leaves a source stuck after a writeback return. A wrong rotation pointer shows up within one round as a different order on `dram_src`. A wrong delay-queue age moves `dram_valid` off cycle c + LATENCY on the very first request. A wrong return index shows up in the same cycle as the wrong `rsp_push` bit.

// File: rtl/arb_pkg.sv
// Package: shared helpers for the credit-based DRAM arbiter.
// Assumes elaboration-time integer arguments only.
package arb_pkg;
    // Bits needed to hold values 0..v inclusive.
    function automatic int cnt_bits(input int v);
        return (v < 1) ? 1 : $clog2(v + 1);
    endfunction
endpackage

// File: rtl/arb_credit_pool.sv
// Module: per-source private credits plus one shared credit pool.
// A return is applied before the borrow of the same cycle, and the
// eligibility flags reflect the counts after that return.
// Assumes private limit 1 and that at most one borrow and one return
// occur per cycle.
module arb_credit_pool #(
    parameter int N_SRC      = 4,
    parameter int SRC_W      = 2,
    parameter int SHARED_LIM = 5,
    parameter bit UNLIM      = 1'b0,
    parameter int CNT_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             brw_en,
    input  logic [SRC_W-1:0] brw_src,
    input  logic             ret_en,
    input  logic [SRC_W-1:0] ret_src,
    output logic [N_SRC-1:0] has_credit
);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(SHARED_LIM);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic [N_SRC-1:0] priv_q, priv_mid, priv_nxt;
    logic [CNT_W-1:0] shr_q, shr_mid, shr_nxt;
    logic             shr_room;

    // Apply the return first, then the borrow.
    always_comb begin
        priv_mid = priv_q;
        shr_mid  = shr_q;
        if (ret_en) begin
            if (priv_q[ret_src]) priv_mid[ret_src] = 1'b0;
            else                 shr_mid = shr_q - 1'b1;
        end
        priv_nxt = priv_mid;
        shr_nxt  = shr_mid;
        if (brw_en) begin
            if (!priv_mid[brw_src]) priv_nxt[brw_src] = 1'b1;
            else                    shr_nxt = shr_mid + 1'b1;
        end
    end

    // Room in the shared pool after this cycle's return.
    assign shr_room = UNLIM || (shr_mid < LIM);

    // One eligibility flag per source.
    for (genvar i = 0; i < N_SRC; i++) begin : g_cred
        assign has_credit[i] = !priv_mid[i] || shr_room;
    end

    // Credit count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            priv_q <= '0;
            shr_q  <= '0;
        end else begin
            priv_q <= priv_nxt;
            shr_q  <= shr_nxt;
        end
    end

    // R11: a shared return never drops the pool below zero.
    assert_shared_nonneg_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_en && !priv_q[ret_src]) |-> (shr_q != '0));
    // R6: a limited pool never exceeds its size.
    assert_shared_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !UNLIM |-> (shr_q <= LIM));
    // R6: an unlimited pool counter must not wrap.
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (brw_en && priv_mid[brw_src]) |-> (shr_mid != TOP));
    // R5: a borrow is only granted to a source holding a credit.
    assert_borrow_ok_R5: assert property (@(posedge clk) disable iff (!rst_n)
        brw_en |-> has_credit[brw_src]);
endmodule

// File: rtl/arb_rotate_pick.sv
// Module: rotating first-eligible picker.
// The scan starts one past the last granted source. The pointer resets
// to N_SRC-1 so that source 0 is scanned first.
// Assumes N_SRC is a power of two and at least 2.
module arb_rotate_pick #(
    parameter int N_SRC = 4,
    parameter int SRC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] elig,
    output logic [N_SRC-1:0] grant,
    output logic             grant_valid,
    output logic [SRC_W-1:0] grant_idx
);
    logic [SRC_W-1:0] last_q;

    // Scan from last_q+1, wrapping on the power-of-two width.
    always_comb begin
        logic [SRC_W-1:0] idx;
        grant_valid = 1'b0;
        grant_idx   = '0;
        for (int k = 0; k < N_SRC; k++) begin
            idx = last_q + SRC_W'(k + 1);
            if (!grant_valid && elig[idx]) begin
                grant_valid = 1'b1;
                grant_idx   = idx;
            end
        end
        grant = grant_valid ? (N_SRC'(1) << grant_idx) : '0;
    end

    // Remember the last borrower.
    always_ff @(posedge clk) begin
        if (!rst_n)           last_q <= SRC_W'(N_SRC - 1);
        else if (grant_valid) last_q <= grant_idx;
    end

    // R2: one grant at most, and only to an eligible source.
    assert_one_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant & ~elig) == '0));
    // R3: some eligible source always wins.
    assert_no_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (elig != '0) |-> grant_valid);
endmodule

// File: rtl/arb_delay_fifo.sv
// Module: fixed-latency delay queue feeding the DRAM.
// Each entry carries an age that saturates at LATENCY. The head may
// leave once its age reaches LATENCY.
// Assumes LATENCY >= 1 and DEPTH >= 2.
module arb_delay_fifo #(
    parameter int DATA_W  = 16,
    parameter int SRC_W   = 2,
    parameter int LATENCY = 3,
    parameter int DEPTH   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic [SRC_W-1:0]  push_src,
    output logic              full,
    output logic              head_ready,
    output logic [DATA_W-1:0] head_data,
    output logic [SRC_W-1:0]  head_src,
    input  logic              pop
);
    import arb_pkg::*;
    localparam int PTR_W = $clog2(DEPTH);
    localparam int AGE_W = cnt_bits(LATENCY);
    localparam int OCC_W = cnt_bits(DEPTH);
    localparam logic [AGE_W-1:0] LAT_A = AGE_W'(LATENCY);

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [SRC_W-1:0]  mem_s [DEPTH];
    logic [AGE_W-1:0]  age   [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [OCC_W-1:0]  occ;

    assign full       = (occ == OCC_W'(DEPTH));
    assign head_ready = (occ != '0) && (age[rd_ptr] >= LAT_A);
    assign head_data  = mem_d[rd_ptr];
    assign head_src   = mem_s[rd_ptr];

    // Payload storage.
    always_ff @(posedge clk) begin
        if (push) begin
            mem_d[wr_ptr] <= push_data;
            mem_s[wr_ptr] <= push_src;
        end
    end

    // Pointers, occupancy and per-entry age.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
            for (int e = 0; e < DEPTH; e++) age[e] <= '0;
        end else begin
            for (int e = 0; e < DEPTH; e++) begin
                if (push && (wr_ptr == PTR_W'(e))) age[e] <= AGE_W'(1);
                else if (age[e] < LAT_A)           age[e] <= age[e] + 1'b1;
            end
            if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            occ <= occ + OCC_W'(push) - OCC_W'(pop);
        end
    end

    // R7: no write into a full queue, no read from an empty one.
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> head_ready);
endmodule

// File: rtl/arb_return_route.sv
// Module: routes the DRAM return head to its source's response queue.
// Converts the global number to a local index, holds the head while the
// target queue is full, and absorbs writeback returns without a push.
// Assumes every return belongs to this channel.
module arb_return_route #(
    parameter int N_SRC   = 4,
    parameter int SRC_W   = 2,
    parameter int GID_W   = 8,
    parameter int DATA_W  = 16,
    parameter int CHAN_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ret_valid,
    input  logic [GID_W-1:0]  ret_gid,
    input  logic              ret_wb,
    input  logic [DATA_W-1:0] ret_data,
    input  logic [N_SRC-1:0]  rsp_full,
    output logic              ret_pop,
    output logic [N_SRC-1:0]  rsp_push,
    output logic [DATA_W-1:0] rsp_data,
    output logic              crd_en,
    output logic [SRC_W-1:0]  crd_src
);
    localparam logic [GID_W-1:0] BASE = GID_W'(CHAN_ID * N_SRC);

    logic [GID_W-1:0] local_id;
    logic [SRC_W-1:0] lidx;

    // Global to local conversion and routing decision.
    always_comb begin
        local_id = ret_gid - BASE;
        lidx     = local_id[SRC_W-1:0];
        ret_pop  = ret_valid && !rsp_full[lidx];
        crd_en   = ret_pop && !ret_wb;
        crd_src  = lidx;
        rsp_push = crd_en ? (N_SRC'(1) << lidx) : '0;
        rsp_data = ret_data;
    end

    // R8: returns must target a source of this channel.
    assert_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> ((ret_gid - BASE) < GID_W'(N_SRC)));
    // R9: never push into a full response queue.
    assert_no_push_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_push & rsp_full) == '0);
    // R10: a writeback never produces a push.
    assert_wb_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && ret_wb) |-> (rsp_push == '0));
endmodule

// File: rtl/credit_dram_arbiter.sv
// Module: top of the credit-based shared DRAM channel arbiter.
// Issues at most one source request per cycle into a fixed-latency
// queue toward the DRAM, paced by private and shared credits. Routes
// DRAM returns back to their sources, which returns the credits.
// Assumes N_SRC is a power of two (>= 2), LATENCY >= 1, and a pool
// size that is not negative when limited.
module credit_dram_arbiter #(
    parameter int N_SRC       = 4,
    parameter int DATA_W      = 16,
    parameter int GID_W       = 8,
    parameter int CHAN_ID     = 0,
    parameter int SCHED_DEPTH = 4,
    parameter int RETQ_DEPTH  = 4,
    parameter int LATENCY     = 3,
    parameter int UNLIM_MAX   = 255,
    localparam int SRC_W      = $clog2(N_SRC)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_SRC-1:0]        req_valid,
    input  logic [N_SRC*DATA_W-1:0] req_data,
    output logic [N_SRC-1:0]        req_pop,
    input  logic [N_SRC-1:0]        rsp_full,
    input  logic                    dram_full,
    output logic                    dram_valid,
    output logic [DATA_W-1:0]       dram_data,
    output logic [SRC_W-1:0]        dram_src,
    input  logic                    ret_valid,
    input  logic [GID_W-1:0]        ret_gid,
    input  logic                    ret_wb,
    input  logic [DATA_W-1:0]       ret_data,
    output logic                    ret_pop,
    output logic [N_SRC-1:0]        rsp_push,
    output logic [DATA_W-1:0]       rsp_data
);
    import arb_pkg::*;
    localparam bit UNLIM      = (SCHED_DEPTH == 0) || (RETQ_DEPTH == 0);
    localparam int SHARED_LIM = UNLIM ? 0 : SCHED_DEPTH + RETQ_DEPTH - (N_SRC - 1);
    localparam int CNT_W      = cnt_bits(UNLIM ? UNLIM_MAX : SHARED_LIM);
    localparam int LQ_DEPTH   = LATENCY + 2;

    logic [N_SRC-1:0]  has_credit, elig, grant;
    logic              grant_valid, lq_full, lq_ready, crd_en;
    logic [SRC_W-1:0]  grant_idx, crd_src;
    logic [DATA_W-1:0] grant_data;

    // A source is eligible when it has work, a credit and response room,
    // and the DRAM path can take a request.
    assign elig       = req_valid & has_credit & ~rsp_full & {N_SRC{!dram_full && !lq_full}};
    assign req_pop    = grant;
    assign grant_data = req_data[grant_idx*DATA_W +: DATA_W];
    assign dram_valid = lq_ready && !dram_full;

    arb_credit_pool #(
        .N_SRC(N_SRC), .SRC_W(SRC_W), .SHARED_LIM(SHARED_LIM),
        .UNLIM(UNLIM), .CNT_W(CNT_W)
    ) u_credit (
        .clk(clk), .rst_n(rst_n),
        .brw_en(grant_valid), .brw_src(grant_idx),
        .ret_en(crd_en), .ret_src(crd_src),
        .has_credit(has_credit)
    );

    arb_rotate_pick #(.N_SRC(N_SRC), .SRC_W(SRC_W)) u_pick (
        .clk(clk), .rst_n(rst_n), .elig(elig),
        .grant(grant), .grant_valid(grant_valid), .grant_idx(grant_idx)
    );

    arb_delay_fifo #(
        .DATA_W(DATA_W), .SRC_W(SRC_W), .LATENCY(LATENCY), .DEPTH(LQ_DEPTH)
    ) u_delay (
        .clk(clk), .rst_n(rst_n),
        .push(grant_valid), .push_data(grant_data), .push_src(grant_idx),
        .full(lq_full), .head_ready(lq_ready),
        .head_data(dram_data), .head_src(dram_src), .pop(dram_valid)
    );

    arb_return_route #(
        .N_SRC(N_SRC), .SRC_W(SRC_W), .GID_W(GID_W),
        .DATA_W(DATA_W), .CHAN_ID(CHAN_ID)
    ) u_route (
        .clk(clk), .rst_n(rst_n),
        .ret_valid(ret_valid), .ret_gid(ret_gid), .ret_wb(ret_wb),
        .ret_data(ret_data), .rsp_full(rsp_full),
        .ret_pop(ret_pop), .rsp_push(rsp_push), .rsp_data(rsp_data),
        .crd_en(crd_en), .crd_src(crd_src)
    );

    // R4: nothing is issued or handed over while the DRAM is full.
    assert_hold_on_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dram_full |-> (req_pop == '0) && !dram_valid);
    // R3: a pop only goes to a source that offered a request.
    assert_pop_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_pop & ~req_valid) == '0);
    // R1: outputs are quiet in the first cycle after reset.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !dram_valid);
endmodule

// File: tb/sim_credit_dram_arbiter.sv
// Scoreboard bench: scenario tasks queue the expected DRAM-side items,
// and a monitor compares them as the design hands requests over.
module sim_credit_dram_arbiter;
    localparam int N = 4, DW = 16, LAT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [N-1:0]    req_valid = '0;
    logic [N*DW-1:0] req_data = '0;
    logic [N-1:0]    req_pop, rsp_full = '0, rsp_push;
    logic            dram_full = 1'b0, dram_valid, ret_valid = 1'b0, ret_wb = 1'b0, ret_pop;
    logic [DW-1:0]   dram_data, ret_data = '0, rsp_data;
    logic [1:0]      dram_src;
    logic [7:0]      ret_gid = '0;

    credit_dram_arbiter #(.N_SRC(N), .DATA_W(DW), .CHAN_ID(1), .LATENCY(LAT)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_data(req_data),
        .req_pop(req_pop), .rsp_full(rsp_full), .dram_full(dram_full),
        .dram_valid(dram_valid), .dram_data(dram_data), .dram_src(dram_src),
        .ret_valid(ret_valid), .ret_gid(ret_gid), .ret_wb(ret_wb), .ret_data(ret_data),
        .ret_pop(ret_pop), .rsp_push(rsp_push), .rsp_data(rsp_data));

    // Second instance with an unlimited shared pool.
    logic [N-1:0]  u1_valid = '0, u1_pop, u1_push;
    logic          u1_dv, u1_rpop;
    logic [DW-1:0] u1_dd, u1_rd;
    logic [1:0]    u1_ds;
    credit_dram_arbiter #(.N_SRC(N), .DATA_W(DW), .RETQ_DEPTH(0), .LATENCY(LAT)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(u1_valid), .req_data('0),
        .req_pop(u1_pop), .rsp_full('0), .dram_full(1'b0),
        .dram_valid(u1_dv), .dram_data(u1_dd), .dram_src(u1_ds),
        .ret_valid(1'b0), .ret_gid('0), .ret_wb(1'b0), .ret_data('0),
        .ret_pop(u1_rpop), .rsp_push(u1_push), .rsp_data(u1_rd));

    int checks = 0, fails = 0, cyc = 0;
    bit done = 1'b0;
    logic [DW-1:0] srcq [N][$];
    logic [17:0]   exp_q [$];
    int            iss_t [$];
    int            pops [N];
    int            u1_cnt = 0;
    bit            u1_count = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: sample at the falling edge, apply source pops after the rising edge.
    always begin
        logic [N-1:0] s_pop;
        @(negedge clk);
        s_pop = req_pop;
        if (rst_n) begin
            if (s_pop != '0) begin
                chk($countones(s_pop) == 1, "R2 one pop per cycle", s_pop, 1);
                iss_t.push_back(cyc);
                for (int i = 0; i < N; i++) if (s_pop[i]) pops[i]++;
            end
            if (dram_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected DRAM item", {dram_src, dram_data}, 0);
                end else begin
                    logic [17:0] e;
                    int lat;
                    e = exp_q.pop_front();
                    chk({dram_src, dram_data} == e, "R2 R7 DRAM item order", {dram_src, dram_data}, e);
                    lat = (iss_t.size() != 0) ? cyc - iss_t.pop_front() : -1;
                    chk(lat == LAT, "R7 latency", lat, LAT);
                end
            end
            if (u1_count && u1_pop[0]) u1_cnt++;
        end
        @(posedge clk);
        #2;
        for (int i = 0; i < N; i++) begin
            if (s_pop[i] && srcq[i].size() != 0) void'(srcq[i].pop_front());
            req_valid[i] = (srcq[i].size() != 0);
            req_data[i*DW +: DW] = (srcq[i].size() != 0) ? srcq[i][0] : '0;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(posedge clk);
        #1;
        rst_n = 1'b0;
        rsp_full = '0; dram_full = 1'b0; ret_valid = 1'b0; ret_wb = 1'b0;
        for (int i = 0; i < N; i++) begin srcq[i].delete(); pops[i] = 0; end
        exp_q.delete();
        iss_t.delete();
        tick(3);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic add_req(input int s, input logic [DW-1:0] d, input bit expect_it);
        srcq[s].push_back(d);
        if (expect_it) exp_q.push_back({2'(s), d});
    endtask

    initial begin
        do_reset();
        // R1 reset state
        @(negedge clk);
        chk(req_pop == '0, "R1 req_pop after reset", req_pop, 0);
        chk(!dram_valid, "R1 dram_valid after reset", dram_valid, 0);
        chk(rsp_push == '0, "R1 rsp_push after reset", rsp_push, 0);
        tick(1);

        // R1 R2 first scan from source 0
        for (int i = 0; i < N; i++) add_req(i, 16'hA000 + 16'(i), 1'b1);
        tick(14);
        chk(exp_q.size() == 0, "R1 all four delivered", exp_q.size(), 0);

        // R2 rotation after last borrower: 2 then 3,0,1
        do_reset();
        add_req(2, 16'hE200, 1'b1);
        tick(6);
        add_req(0, 16'hE000, 1'b0); add_req(1, 16'hE100, 1'b0); add_req(3, 16'hE300, 1'b0);
        exp_q.push_back({2'd3, 16'hE300});
        exp_q.push_back({2'd0, 16'hE000});
        exp_q.push_back({2'd1, 16'hE100});
        tick(14);
        chk(exp_q.size() == 0, "R2 rotation drained", exp_q.size(), 0);

        // R5 R6 R10 R11 credits
        do_reset();
        for (int k = 0; k < 8; k++) add_req(0, 16'hB000 + 16'(k), k < 6);
        tick(20);
        chk(pops[0] == 6, "R6 shared limit stalls source 0", pops[0], 6);
        add_req(1, 16'hB100, 1'b1);
        tick(8);
        chk(pops[1] == 1, "R5 private credit gives progress", pops[1], 1);
        ret_valid = 1'b1; ret_gid = 8'd4; ret_wb = 1'b1; ret_data = 16'h0011;
        @(negedge clk);
        chk(ret_pop, "R10 writeback popped", ret_pop, 1);
        chk(rsp_push == '0, "R10 writeback not pushed", rsp_push, 0);
        tick(1);
        ret_valid = 1'b0; ret_wb = 1'b0;
        tick(8);
        chk(pops[0] == 6, "R10 writeback returns no credit", pops[0], 6);
        ret_valid = 1'b1; ret_gid = 8'd4; ret_data = 16'h0055;
        @(negedge clk);
        chk(rsp_push == 4'b0001, "R8 route global 4 to local 0", rsp_push, 1);
        chk(rsp_data == 16'h0055, "R8 response data", rsp_data, 16'h0055);
        tick(1);
        ret_valid = 1'b0;
        exp_q.push_back({2'd0, 16'hB006});
        tick(10);
        chk(pops[0] == 7, "R11 returned credit reissues", pops[0], 7);

        // R3 skip a source whose response queue is full
        do_reset();
        rsp_full = 4'b0001;
        add_req(0, 16'hC000, 1'b0);
        add_req(1, 16'hC100, 1'b1);
        tick(6);
        chk(pops[0] == 0 && pops[1] == 1, "R3 full source skipped", pops[0], 0);
        rsp_full = '0;
        exp_q.push_back({2'd0, 16'hC000});
        tick(8);
        chk(pops[0] == 1, "R3 source issues once room returns", pops[0], 1);

        // R4 DRAM full blocks issue
        do_reset();
        dram_full = 1'b1;
        add_req(2, 16'hD200, 1'b1);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk(req_pop == '0 && !dram_valid, "R4 blocked while full", req_pop, 0);
        end
        tick(1);
        dram_full = 1'b0;
        tick(8);
        chk(pops[2] == 1 && exp_q.size() == 0, "R4 issue after full clears", pops[2], 1);

        // R9 hold then R8 route
        do_reset();
        add_req(2, 16'hF200, 1'b1);
        tick(8);
        rsp_full = 4'b0100;
        ret_valid = 1'b1; ret_gid = 8'd6; ret_data = 16'h0077;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(!ret_pop && rsp_push == '0, "R9 held while target full", rsp_push, 0);
        end
        tick(1);
        rsp_full = '0;
        @(negedge clk);
        chk(ret_pop && rsp_push == 4'b0100, "R8 route global 6 to local 2", rsp_push, 4);
        chk(rsp_data == 16'h0077, "R8 held data delivered", rsp_data, 16'h0077);
        tick(1);
        ret_valid = 1'b0;

        // R6 unlimited pool issues every cycle
        do_reset();
        u1_valid = 4'b0001;
        u1_cnt = 0;
        u1_count = 1'b1;
        tick(20);
        u1_count = 1'b0;
        u1_valid = '0;
        chk(u1_cnt == 20, "R6 unlimited pool never stalls", u1_cnt, 20);

        tick(4);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule